// File: doc/BRIEF.md
# Hamming Sector Code Checker

This block decides what to do with one 512-byte flash sector after a read. It receives two 3-byte Hamming codes: the code that was saved in the page's spare area when the sector was written, and the code that the read-path generator produced over the data just read. Both codes are rearranged into a 32-bit word with a fixed nibble layout, and the two words are XORed to form a syndrome. The block then counts the ones in the syndrome and sorts the result into one of five outcomes: clean, fixable single-bit data error, fault inside the stored code, erased page, or uncorrectable.

For a fixable error the block returns the byte address inside the sector and a one-hot mask of the bit to invert. The caller applies the mask to its own sector buffer. Producing the code over the data and modifying the buffer are left to neighbouring logic. A single-cycle `start` launches a check. The verdict arrives on a fixed schedule, marked by a one-cycle `done`, and stays on the outputs until the next verdict replaces it.

Top module: `ham_sector_chk`

## Requirements
- R1: Each 3-byte code (byte k in bits 8k+7:8k of the port) is rearranged into a 32-bit word: byte 0 in bits 7:0, byte 1 in bits 23:16, byte 2's upper nibble in bits 27:24 and its lower nibble in bits 11:8, all other bits zero. The syndrome is the XOR of the two rearranged words.
- R2: A zero syndrome gives status 0 (clean).
- R3: A syndrome with exactly 12 ones gives status 1 (fixable). `fix_addr` is syndrome bits 27:19 and the bit index is syndrome bits 18:16.
- R4: With status 1, `fix_mask` has exactly one bit set, at the bit index. With any other status, `fix_mask` and `fix_addr` are zero.
- R5: A syndrome with exactly one set bit gives status 2 (stored code damaged). No data correction is requested.
- R6: A stored code whose rearranged word is 0x0FFF0FFF (all three bytes 0xFF), together with a computed code of zero, gives status 3 (erased page, treated as success).
- R7: Any other non-zero syndrome gives status 4 (uncorrectable).
- R8: `done` is high for exactly one cycle. It rises in the cycle that follows the third rising edge counted from the edge that samples `start`, and it carries that start's result.
- R9: `status`, `fix_addr` and `fix_mask` keep their values from one `done` until the next.
- R10: While reset is asserted and after it is released, `done`, `status`, `fix_addr` and `fix_mask` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle strobe that samples both codes |
| stored_code | input | 24 | Code read back from the spare area, byte 0 in bits 7:0 |
| calc_code | input | 24 | Code computed over the sector data just read |
| status | output | 3 | Verdict: 0 clean, 1 fixable, 2 code fault, 3 erased, 4 uncorrectable |
| fix_addr | output | 9 | Byte address inside the sector to correct |
| fix_mask | output | 8 | One-hot mask of the bit to invert |
| done | output | 1 | One-cycle pulse when a new verdict is presented |

## Verification
The bench walks all 4096 syndromes with one bit of every parity pair set, so that every byte address and every bit index shows up at least once. A wrong nibble placement or a shifted address field would put the fix at the wrong byte or bit. It also flips each of the 24 code bits one at a time; a design that mixed up the popcount-of-one rule with the single-bit data case would ask for a data correction on those. All 276 two-bit differences must come back uncorrectable. The all-ones stored code is tried with a zero computed code, which must give erased, and with a computed code one bit away from zero, which must give uncorrectable. A design that matched only on the stored pattern would report erased in both cases. After each verdict the bench checks that `done` falls and the outputs stay put, which catches a pulse held too long or outputs that drift.

// File: rtl/ham_chk_pkg.sv
package ham_chk_pkg;

  typedef enum logic [2:0] {
    ST_CLEAN      = 3'd0,
    ST_FIXABLE    = 3'd1,
    ST_CODE_FAULT = 3'd2,
    ST_ERASED     = 3'd3,
    ST_MULTI      = 3'd4
  } chk_status_e;

endpackage

// File: rtl/ham_code_fmt.sv
// Rearranges a 3-byte code into the nibble-split working word.
module ham_code_fmt #(
  parameter int BYTE_W = 8
) (
  input  logic [3*BYTE_W-1:0] code_in,
  output logic [4*BYTE_W-1:0] word_out
);
  localparam int NIB_W = BYTE_W / 2;

  always_comb begin
    word_out = '0;
    word_out[BYTE_W-1:0]                 = code_in[BYTE_W-1:0];
    word_out[3*BYTE_W-1:2*BYTE_W]        = code_in[2*BYTE_W-1:BYTE_W];
    word_out[3*BYTE_W+NIB_W-1:3*BYTE_W]  = code_in[3*BYTE_W-1:2*BYTE_W+NIB_W];
    word_out[BYTE_W+NIB_W-1:BYTE_W]      = code_in[2*BYTE_W+NIB_W-1:2*BYTE_W];
  end
endmodule

// File: rtl/ham_popcount.sv
// Counts set bits of a word.
module ham_popcount #(
  parameter int W = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] ones
);
  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) begin
      ones = ones + CW'(vec[i]);
    end
  end
endmodule

// File: rtl/ham_classify.sv
// Turns syndrome, its popcount and the erased flag into a verdict.
module ham_classify
  import ham_chk_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int BIT_W  = 3,
  localparam int WORD_W = 4 * BYTE_W,
  localparam int CW     = $clog2(WORD_W + 1),
  localparam int PAIRS  = 3 * BYTE_W / 2,
  localparam int ADDR_W = PAIRS - BIT_W,
  localparam int MASK_W = 1 << BIT_W,
  localparam int FLD_LO = 2 * BYTE_W
) (
  input  logic [WORD_W-1:0] syn,
  input  logic [CW-1:0]     ones,
  input  logic              erased,
  output chk_status_e       verdict,
  output logic [ADDR_W-1:0] addr,
  output logic [MASK_W-1:0] mask
);
  logic [BIT_W-1:0] bit_sel;

  assign bit_sel = syn[FLD_LO +: BIT_W];

  always_comb begin
    verdict = ST_MULTI;
    addr    = '0;
    mask    = '0;
    if (syn == '0) begin
      verdict = ST_CLEAN;
    end else if (ones == CW'(PAIRS)) begin
      verdict = ST_FIXABLE;
      addr    = syn[FLD_LO+BIT_W +: ADDR_W];
      mask    = MASK_W'(1) << bit_sel;
    end else if (ones == CW'(1)) begin
      verdict = ST_CODE_FAULT;
    end else if (erased) begin
      verdict = ST_ERASED;
    end
  end
endmodule

// File: rtl/ham_sector_chk.sv
// Three-stage check: capture+syndrome, popcount, classify.
module ham_sector_chk
  import ham_chk_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int BIT_W  = 3,
  localparam int CODE_W = 3 * BYTE_W,
  localparam int WORD_W = 4 * BYTE_W,
  localparam int NIB_W  = BYTE_W / 2,
  localparam int CW     = $clog2(WORD_W + 1),
  localparam int ADDR_W = 3 * BYTE_W / 2 - BIT_W,
  localparam int MASK_W = 1 << BIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] stored_code,
  input  logic [CODE_W-1:0] calc_code,
  output logic [2:0]        status,
  output logic [ADDR_W-1:0] fix_addr,
  output logic [MASK_W-1:0] fix_mask,
  output logic              done
);
  // Rearranged pattern of a blank spare area
  localparam logic [WORD_W-1:0] ERASED_PAT =
    {{NIB_W{1'b0}}, {NIB_W{1'b1}}, {BYTE_W{1'b1}},
     {NIB_W{1'b0}}, {NIB_W{1'b1}}, {BYTE_W{1'b1}}};

  logic [WORD_W-1:0] stored_w, calc_w;
  logic [WORD_W-1:0] s1_syn_d, s1_syn_q, s2_syn_q;
  logic              s1_erased_d, s1_erased_q, s2_erased_q;
  logic              s1_vld_q, s2_vld_q;
  logic [CW-1:0]     ones_d, s2_ones_q;
  chk_status_e       verdict_d;
  logic [ADDR_W-1:0] addr_d;
  logic [MASK_W-1:0] mask_d;

  ham_code_fmt #(.BYTE_W(BYTE_W)) u_fmt_stored (
    .code_in (stored_code),
    .word_out(stored_w)
  );

  ham_code_fmt #(.BYTE_W(BYTE_W)) u_fmt_calc (
    .code_in (calc_code),
    .word_out(calc_w)
  );

  // Stage 1 next state
  always_comb begin
    s1_syn_d    = stored_w ^ calc_w;
    s1_erased_d = (stored_w == ERASED_PAT) && (calc_w == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q    <= 1'b0;
      s1_syn_q    <= '0;
      s1_erased_q <= 1'b0;
    end else begin
      s1_vld_q <= start;
      if (start) begin
        s1_syn_q    <= s1_syn_d;
        s1_erased_q <= s1_erased_d;
      end
    end
  end

  // Stage 2: popcount
  ham_popcount #(.W(WORD_W)) u_pop (
    .vec (s1_syn_q),
    .ones(ones_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_vld_q    <= 1'b0;
      s2_syn_q    <= '0;
      s2_ones_q   <= '0;
      s2_erased_q <= 1'b0;
    end else begin
      s2_vld_q <= s1_vld_q;
      if (s1_vld_q) begin
        s2_syn_q    <= s1_syn_q;
        s2_ones_q   <= ones_d;
        s2_erased_q <= s1_erased_q;
      end
    end
  end

  // Stage 3: classify and hold
  ham_classify #(.BYTE_W(BYTE_W), .BIT_W(BIT_W)) u_cls (
    .syn    (s2_syn_q),
    .ones   (s2_ones_q),
    .erased (s2_erased_q),
    .verdict(verdict_d),
    .addr   (addr_d),
    .mask   (mask_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      status   <= 3'd0;
      fix_addr <= '0;
      fix_mask <= '0;
    end else begin
      done <= s2_vld_q;
      if (s2_vld_q) begin
        status   <= verdict_d;
        fix_addr <= addr_d;
        fix_mask <= mask_d;
      end
    end
  end

endmodule

// File: rtl/ham_sector_chk_sva.sv
module ham_sector_chk_sva #(
  parameter int ADDR_W = 9,
  parameter int MASK_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [2:0]        status,
  input logic [ADDR_W-1:0] fix_addr,
  input logic [MASK_W-1:0] fix_mask,
  input logic              done
);
  // R4: a fix request names exactly one bit
  a_r4_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'd1) |-> ($countones(fix_mask) == 1));

  // R4: no fix data unless fixable
  a_r4_idle_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 3'd1) |-> (fix_mask == '0 && fix_addr == '0));

  // R5: stored-code fault never asks for a data fix
  a_r5_no_fix_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'd2) |-> (fix_mask == '0));

  // R8: done only follows a start three edges earlier
  a_r8_done_origin: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start, 3));

  // R9: verdict held between pulses
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(status) && $stable(fix_addr) && $stable(fix_mask));

  // R7: only defined codes appear
  a_r7_legal_status: assert property (@(posedge clk) disable iff (!rst_n)
    status <= 3'd4);
endmodule

bind ham_sector_chk ham_sector_chk_sva #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_sva (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .status  (status),
  .fix_addr(fix_addr),
  .fix_mask(fix_mask),
  .done    (done)
);

// File: tb/ham_sector_chk_test.sv
`timescale 1ns/1ps
module ham_sector_chk_test;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [23:0] stored_code;
  logic [23:0] calc_code;
  logic [2:0]  status;
  logic [8:0]  fix_addr;
  logic [7:0]  fix_mask;
  logic        done;

  int n_vec;
  int n_bad;
  bit finished;

  ham_sector_chk uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .stored_code(stored_code),
    .calc_code  (calc_code),
    .status     (status),
    .fix_addr   (fix_addr),
    .fix_mask   (fix_mask),
    .done       (done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Converts a 32-bit working-layout difference back into 3 code bytes
  function automatic logic [23:0] unfmt(input logic [31:0] w);
    return {w[27:24], w[11:8], w[23:16], w[7:0]};
  endfunction

  task automatic run(input logic [23:0] st, input logic [23:0] cc,
                     input logic [2:0] e_st, input logic [8:0] e_addr,
                     input logic [7:0] e_mask, input string tag);
    @(negedge clk);
    stored_code = st;
    calc_code   = cc;
    start       = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    stored_code = ~st;
    calc_code   = ~cc;
    chk({"R8 done early ", tag}, {31'd0, done}, 32'd0);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk({"R8 done ", tag}, {31'd0, done}, 32'd1);
    chk({tag, " status"}, {29'd0, status}, {29'd0, e_st});
    chk({tag, " addr"}, {23'd0, fix_addr}, {23'd0, e_addr});
    chk({tag, " mask"}, {24'd0, fix_mask}, {24'd0, e_mask});
    @(negedge clk);
    chk({"R8 pulse width ", tag}, {31'd0, done}, 32'd0);
    chk({"R9 hold ", tag}, {20'd0, status, fix_addr}, {20'd0, e_st, e_addr});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] base;
    n_vec = 0; n_bad = 0; finished = 1'b0;
    rst_n = 1'b0; start = 1'b0; stored_code = '0; calc_code = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset outs", {19'd0, done, status, fix_addr, fix_mask}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after release", {19'd0, done, status, fix_addr, fix_mask}, 32'd0);

    // R2: equal codes
    run(24'h000000, 24'h000000, 3'd0, 9'd0, 8'd0, "R2 zeros");
    run(24'h5A3C91, 24'h5A3C91, 3'd0, 9'd0, 8'd0, "R2 equal");
    run(24'hFFFFFF, 24'hFFFFFF, 3'd0, 9'd0, 8'd0, "R2 ones");

    // R3/R1: every address and bit index, pair-complement syndromes
    base = 24'h3A96C5;
    for (int v = 0; v < 4096; v++) begin
      logic [11:0] f;
      logic [31:0] syn;
      f   = 12'(v);
      syn = {4'h0, f, 4'h0, ~f};
      run(base ^ unfmt(syn), base, 3'd1, f[11:3], 8'(1) << f[2:0], "R3 fix");
      base = {base[22:0], base[23] ^ base[18]};
    end

    // R5: single-bit difference anywhere in the code
    for (int b = 0; b < 24; b++) begin
      run(24'hC0FFEE ^ (24'd1 << b), 24'hC0FFEE, 3'd2, 9'd0, 8'd0, "R5 code fault");
    end

    // R7: every two-bit difference
    for (int a = 0; a < 24; a++) begin
      for (int b = a + 1; b < 24; b++) begin
        run(24'h123456 ^ (24'd1 << a) ^ (24'd1 << b), 24'h123456, 3'd4, 9'd0, 8'd0, "R7 two bits");
      end
    end

    // R6: erased page and near-misses
    run(24'hFFFFFF, 24'h000000, 3'd3, 9'd0, 8'd0, "R6 erased");
    run(24'hFFFFFF, 24'h000001, 3'd4, 9'd0, 8'd0, "R7 not erased calc");
    run(24'hFFFFFE, 24'h000000, 3'd4, 9'd0, 8'd0, "R7 not erased stored");

    // R9: hold across idle cycles
    run(24'h000000, unfmt({4'h0, 12'hABC, 4'h0, 12'h543}), 3'd1, 9'h157, 8'h10, "R3 calc side");
    repeat (6) begin
      @(negedge clk);
      chk("R9 idle", {18'd0, done, status, fix_addr, fix_mask}, {18'd0, 1'b0, 3'd1, 9'h157, 8'h10});
    end

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule